// File: doc/BRIEF.md
# ADC Serial Control Slave

This block is the two-wire serial slave in front of a 12-bit sampling converter. It watches oversampled clock and data lines, recognises start, repeated start and stop conditions, and answers to one 7-bit device address. A write stores a 6-bit configuration word for the converter. A read returns the most recent conversion result as two bytes.

While the converter reports that it is busy, the slave does not acknowledge its own address. A stop that closes a complete two-byte read issues a one-cycle start pulse to the converter. The data output is an active-high pull-down enable for an open-drain pad. Both bus lines are resynchronised to the system clock, which must run at least 16 times faster than the serial clock.

Top module: `adc_i2c_slave`

## Requirements
- R1: In the clock after synchronous reset is high, `sda_oe` is 0, `cfg_o` is 0 and `conv_start_o` is 0.
- R2: The first byte after a start is seven address bits, MSB first, then a direction bit (1 = read, 0 = write). If the address equals `own_addr_i` as sampled during reset and the converter is idle, the slave pulls SDA low in the ninth clock. Otherwise it leaves SDA released and ignores the rest of the transfer. Changes of `own_addr_i` after reset have no effect.
- R3: While `conv_busy_i` is 1 when the address byte completes, the slave leaves SDA released for both read and write requests.
- R4: In a write, `cfg_o` takes bits [7:2] of each data byte and the slave acknowledges the byte. Bits [1:0] are ignored. `cfg_o` changes at no other time.
- R5: In a read, the slave sends `result_i[11:4]` first, then `{result_i[3:0], 4'b0000}`, each MSB first. The result is captured when the address is acknowledged.
- R6: A stop that follows a completed second read byte produces exactly one `conv_start_o` pulse, one clock wide.
- R7: If the master does not acknowledge the first read byte, the slave releases SDA, and the following stop produces no pulse. A stop after a write produces no pulse.
- R8: A repeated start with no stop before it returns the slave to the address phase.
- R9: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr_i | input | 7 | Device address, sampled during reset |
| conv_busy_i | input | 1 | Converter is converting |
| result_i | input | 12 | Last conversion result |
| cfg_o | output | 6 | Channel and mode configuration |
| conv_start_o | output | 1 | One-clock request for a new conversion |

## Verification
The bench targets the address-phase decision. A slave that ignored the busy input would acknowledge during a conversion. One that kept following `own_addr_i` after reset would answer to the wrong address. The read tests check the nibble packing of the second byte, where a wrong shift or pad shows up as a wrong byte value. They also cover a master that stops early: a trigger armed too soon would raise a pulse after a one-byte read. A repeated start between a write and a read checks that the slave goes back to address decoding, and a monitor flags any change of the pull-down while the clock is high.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave #(
  parameter int ADDR_W      = 7,
  parameter int RES_W       = 12,
  parameter int CFG_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              conv_busy_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              conv_start_o
);
  import adc_i2c_pkg::*;

  localparam int BYTE_W = 8;
  localparam int LO_W   = RES_W - BYTE_W;
  localparam int PAD_W  = BYTE_W - LO_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s)
  );
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s)
  );
  i2c_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  slv_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [LO_W-1:0]   res_lo;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, byte_idx, mst_ack, rd_done;

  always_ff @(posedge clk) begin
    conv_start_o <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      res_lo   <= '0;
      addr_q   <= own_addr_i;
      rw_q     <= 1'b0;
      byte_idx <= 1'b0;
      mst_ack  <= 1'b0;
      rd_done  <= 1'b0;
      sda_oe   <= 1'b0;
      cfg_o    <= '0;
    end else if (stop_det) begin
      state        <= ST_IDLE;
      sda_oe       <= 1'b0;
      conv_start_o <= rd_done;
      rd_done      <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (state == ST_ADDR || state == ST_WR || state == ST_RD)
          bit_cnt <= bit_cnt + 1'b1;
        if (state == ST_ADDR || state == ST_WR)
          rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
        if (state == ST_RD_ACK)
          mst_ack <= ~sda_s;
      end
      if (scl_fall) begin
        case (state)
          ST_ADDR: if (bit_cnt == FULL) begin
            bit_cnt <= '0;
            if (rx_sh[BYTE_W-1:1] == addr_q && !conv_busy_i) begin
              sda_oe <= 1'b1;
              rw_q   <= rx_sh[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR_ACK: begin
            if (rw_q) begin
              tx_sh    <= result_i[RES_W-1 -: BYTE_W];
              res_lo   <= result_i[LO_W-1:0];
              sda_oe   <= ~result_i[RES_W-1];
              byte_idx <= 1'b0;
              state    <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_WR: if (bit_cnt == FULL) begin
            bit_cnt <= '0;
            cfg_o   <= rx_sh[BYTE_W-1 -: CFG_W];
            sda_oe  <= 1'b1;
            state   <= ST_WR_ACK;
          end
          ST_WR_ACK: begin
            sda_oe <= 1'b0;
            state  <= ST_WR;
          end
          ST_RD: begin
            if (bit_cnt == FULL) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              state   <= ST_RD_ACK;
            end else begin
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[BYTE_W-2];
            end
          end
          ST_RD_ACK: begin
            if (byte_idx) begin
              rd_done <= 1'b1;
              state   <= ST_SKIP;
            end else if (mst_ack) begin
              tx_sh    <= {res_lo, {PAD_W{1'b0}}};
              sda_oe   <= ~res_lo[LO_W-1];
              byte_idx <= 1'b1;
              state    <= ST_RD;
            end else begin
              state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk #(
  parameter int CFG_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [CFG_W-1:0] cfg_o,
  input logic             conv_start_o,
  input logic             stop_seen
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!sda_oe && !conv_start_o && cfg_o == '0));

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_cfg_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_o != $past(cfg_o)) |-> (sda_oe && !$past(sda_oe)));

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  p_pulse_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |-> $past(stop_seen));
endmodule

bind adc_i2c_slave adc_i2c_slave_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_o(cfg_o), .conv_start_o(conv_start_o), .stop_seen(stop_det)
);

// File: tb/adc_i2c_slave_tb.sv
module adc_i2c_slave_tb;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h2A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_oe, conv_start_o, conv_busy_i = 1'b0;
  logic [6:0]  own_addr_i = DEV;
  logic [11:0] result_i = '0;
  logic [5:0]  cfg_o;
  wire         sda_line = sda_m & ~sda_oe;
  int checks = 0, failures = 0, pulses = 0, r9_bad = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  adc_i2c_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr_i(own_addr_i), .conv_busy_i(conv_busy_i), .result_i(result_i),
    .cfg_o(cfg_o), .conv_start_o(conv_start_o)
  );

  always @(posedge clk) if (!rst && conv_start_o) pulses++;
  always @(negedge clk) begin
    if (!rst && sda_oe != oe_prev && scl_m) r9_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_rstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bus_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic send_bit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq(); endtask
  task automatic recv_bit(output logic b); sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; wq(); scl_m = 0; wq(); endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack_it);
  endtask

  task automatic t_reset();
    check(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    check(cfg_o == 0, "R1 cfg_o", cfg_o, 0);
    check(conv_start_o == 0, "R1 conv_start_o", conv_start_o, 0);
  endtask

  task automatic t_write();
    logic ack; int p0 = pulses;
    own_addr_i = 7'h11;
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check(ack, "R2 address ack (latched at reset)", ack, 1);
    send_byte(8'hB7, ack);
    check(ack, "R4 data ack", ack, 1);
    bus_stop();
    check(cfg_o == 6'h2D, "R4 cfg upper bits", cfg_o, 6'h2D);
    check(pulses == p0, "R7 no pulse after write", pulses, p0);
  endtask

  task automatic t_wrong_addr();
    logic ack;
    bus_start(); send_byte({7'h11, 1'b0}, ack);
    check(!ack, "R2 mismatch nak", ack, 0);
    send_byte(8'h00, ack);
    bus_stop();
    check(cfg_o == 6'h2D, "R2 ignored write keeps cfg", cfg_o, 6'h2D);
  endtask

  task automatic t_busy();
    logic ack;
    conv_busy_i = 1;
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check(!ack, "R3 busy write nak", ack, 0);
    bus_stop();
    bus_start(); send_byte({DEV, 1'b1}, ack);
    check(!ack, "R3 busy read nak", ack, 0);
    bus_stop();
    check(cfg_o == 6'h2D, "R3 cfg unchanged", cfg_o, 6'h2D);
    conv_busy_i = 0;
  endtask

  task automatic t_read_full(input logic [11:0] val);
    logic ack; logic [7:0] d; int p0 = pulses;
    result_i = val;
    bus_start(); send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    recv_byte(1'b1, d);
    check(d == val[11:4], "R5 first byte", d, val[11:4]);
    recv_byte(1'b0, d);
    check(d == {val[3:0], 4'h0}, "R5 second byte", d, {val[3:0], 4'h0});
    bus_stop(); wq();
    check(pulses == p0 + 1, "R6 one pulse after full read", pulses, p0 + 1);
  endtask

  task automatic t_read_short();
    logic ack; logic [7:0] d; int p0 = pulses;
    result_i = 12'h3F1;
    bus_start(); send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d);
    check(d == 8'h3F, "R5 short read byte", d, 8'h3F);
    check(sda_oe == 0, "R7 released after nak", sda_oe, 0);
    bus_stop(); wq();
    check(pulses == p0, "R7 no pulse after short read", pulses, p0);
  endtask

  task automatic t_rstart();
    logic ack; logic [7:0] d; int p0 = pulses;
    result_i = 12'h123;
    bus_start(); send_byte({DEV, 1'b0}, ack);
    send_byte(8'h44, ack);
    check(cfg_o == 6'h11, "R4 cfg second write", cfg_o, 6'h11);
    bus_rstart(); send_byte({DEV, 1'b1}, ack);
    check(ack, "R8 address ack after repeated start", ack, 1);
    recv_byte(1'b1, d);
    check(d == 8'h12, "R8 read after repeated start", d, 8'h12);
    recv_byte(1'b0, d);
    check(d == 8'h30, "R5 second byte padding", d, 8'h30);
    bus_stop(); wq();
    check(pulses == p0 + 1, "R6 pulse after repeated-start read", pulses, p0 + 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    wq();
    t_write();
    t_wrong_addr();
    t_busy();
    t_read_full(12'hA5C);
    t_read_short();
    t_rstart();
    check(r9_bad == 0, "R9 sda_oe moved while SCL high", r9_bad, 0);
    finish_run();
  end
endmodule